// File: doc/BRIEF.md
# Bus Data Width Adapter

This adapter sits between a 32-bit bus master and a memory-mapped slave whose data path is either narrower (16 bits) or wider (64 bits). It maps the slave's storage into the master's byte-address space so that it appears contiguous. A parameter fixes the slave width at build time, and that choice selects one of two steering variants.

With a 16-bit slave, each master word covers two consecutive slave halfwords. The lower-numbered halfword sits in bits 15:0 and the higher-numbered one in bits 31:16. Byte-address bit 1 selects which half of the master's write data reaches the slave. Read data always comes back in the low half with the upper half cleared. With a 64-bit slave, each slave location holds two consecutive master words, the lower-numbered word in bits 31:0. Byte-address bit 2 selects the half on reads and the lane enable on writes.

The master address port carries only the byte-address bits at or above the access granularity: bits [AW-1:1] for the narrow slave and bits [AW-1:2] for the wide slave. The whole block is combinational, and the read and write strobes pass through unchanged.

Top module: `bus_width_adapter`

## Requirements
- R1: Narrow mode: the slave write data is master write bits 15:0 when byte-address bit 1 is 0, and bits 31:16 when it is 1.
- R2: Narrow mode: master read data is the slave halfword in bits 15:0, with bits 31:16 zero, for either value of address bit 1.
- R3: Narrow mode: the slave address is the master byte address shifted right by one. A halfword written at byte address A reads back at byte address A.
- R4: Wide mode: master read data is slave bits 31:0 when byte-address bit 2 is 0, and bits 63:32 when it is 1.
- R5: Wide mode: the master write word is driven onto both halves of the slave write data. The two-bit lane enable is 01 when address bit 2 is 0 and 10 when it is 1.
- R6: Wide mode: the slave address is the master byte address shifted right by three. A word written at byte address A reads back at byte address A.
- R7: In both modes the slave read and write strobes equal the master read and write strobes in the same cycle.
- R8: Narrow mode: the single lane enable is always 1. A write to one halfword leaves the other halfword of the same master word unchanged, and in wide mode a write leaves the other word of the same slave location unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_addr | input | AW-LSB | Master byte address, bits [AW-1:LSB]; LSB is 1 for the narrow slave and 2 for the wide slave |
| m_wdata | input | 32 | Master write data |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_rdata | output | 32 | Read data returned to the master |
| s_addr | output | AW-OFS | Slave location address; OFS is 1 for the narrow slave and 3 for the wide slave |
| s_wdata | output | SLAVE_W | Write data to the slave |
| s_lane | output | LANES | Per-32-bit-lane write enable (one bit for the narrow slave) |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_rdata | input | SLAVE_W | Read data from the slave |

## Verification
The hardest case to reach is a partial write that must preserve the neighbouring half of the same master word or slave location. Lane or halfword steering errors show up only when that other half is read back later. The bench models the slave as real storage and keeps a byte-level view of the master address space. It first writes both halves of one word with distinct patterns and reads each back, then runs long random mixes of reads and writes over a small address range. This makes overlapping partial writes to the same location frequent.

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
  parameter int AW      = 8,
  parameter int SLAVE_W = 16,
  localparam int LSB    = (SLAVE_W == 64) ? 2 : 1,
  localparam int OFS    = (SLAVE_W == 64) ? 3 : 1,
  localparam int LANES  = (SLAVE_W == 64) ? 2 : 1
) (
  input  logic [AW-1:LSB]     m_addr,
  input  logic [31:0]         m_wdata,
  input  logic                m_rd,
  input  logic                m_wr,
  output logic [31:0]         m_rdata,
  output logic [AW-1:OFS]     s_addr,
  output logic [SLAVE_W-1:0]  s_wdata,
  output logic [LANES-1:0]    s_lane,
  output logic                s_rd,
  output logic                s_wr,
  input  logic [SLAVE_W-1:0]  s_rdata
);

  assign s_rd = m_rd;
  assign s_wr = m_wr;

  if (SLAVE_W == 64) begin : g_wide
    logic hi_word;
    assign hi_word = m_addr[2];
    assign s_addr  = m_addr[AW-1:3];
    assign s_wdata = {m_wdata, m_wdata};
    assign s_lane  = hi_word ? 2'b10 : 2'b01;
    assign m_rdata = hi_word ? s_rdata[63:32] : s_rdata[31:0];
  end else begin : g_narrow
    logic hi_half;
    assign hi_half = m_addr[1];
    assign s_addr  = m_addr;
    assign s_wdata = hi_half ? m_wdata[31:16] : m_wdata[15:0];
    assign s_lane  = 1'b1;
    assign m_rdata = {16'h0000, s_rdata};
  end

endmodule

// File: rtl/bus_width_adapter_chk.sv
module bus_width_adapter_chk #(
  parameter int SLAVE_W = 16,
  localparam int LANES  = (SLAVE_W == 64) ? 2 : 1
) (
  input logic [31:0]         m_wdata,
  input logic                m_rd,
  input logic                m_wr,
  input logic [31:0]         m_rdata,
  input logic [SLAVE_W-1:0]  s_wdata,
  input logic [LANES-1:0]    s_lane,
  input logic                s_rd,
  input logic                s_wr,
  input logic [SLAVE_W-1:0]  s_rdata
);

  always_comb begin
    a_r7_strobes: assert ({s_rd, s_wr} == {m_rd, m_wr});
  end

  if (SLAVE_W == 64) begin : g_wide
    always_comb begin
      a_r4_read_half: assert (m_rdata == s_rdata[31:0] || m_rdata == s_rdata[63:32]);
      a_r5_dup: assert (s_wdata[63:32] == s_wdata[31:0] && s_wdata[31:0] == m_wdata);
      a_r5_lane: assert ($countones(s_lane) == 1);
    end
  end else begin : g_narrow
    always_comb begin
      a_r1_half_pick: assert (s_wdata == m_wdata[15:0] || s_wdata == m_wdata[31:16]);
      a_r2_zero_ext: assert (m_rdata[31:16] == 16'h0000 && m_rdata[15:0] == s_rdata);
      a_r8_lane_on: assert (s_lane == 1'b1);
    end
  end

endmodule

bind bus_width_adapter bus_width_adapter_chk #(.SLAVE_W(SLAVE_W)) u_chk (
  .m_wdata(m_wdata), .m_rd(m_rd), .m_wr(m_wr), .m_rdata(m_rdata),
  .s_wdata(s_wdata), .s_lane(s_lane), .s_rd(s_rd), .s_wr(s_wr),
  .s_rdata(s_rdata)
);

// File: tb/bus_width_adapter_tb.sv
`timescale 1ns/1ps
module bus_width_adapter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // narrow instance
  logic [7:1]  n_addr = '0;
  logic [31:0] n_wd = '0;
  logic        n_rd = 1'b0, n_wr = 1'b0;
  logic [31:0] n_rdata;
  logic [7:1]  n_saddr;
  logic [15:0] n_swd;
  logic [0:0]  n_lane;
  logic        n_srd, n_swr;
  logic [15:0] n_srdata;

  // wide instance
  logic [7:2]  w_addr = '0;
  logic [31:0] w_wd = '0;
  logic        w_rd = 1'b0, w_wr = 1'b0;
  logic [31:0] w_rdata;
  logic [7:3]  w_saddr;
  logic [63:0] w_swd;
  logic [1:0]  w_lane;
  logic        w_srd, w_swr;
  logic [63:0] w_srdata;

  bus_width_adapter #(.AW(8), .SLAVE_W(16)) u_dut (
    .m_addr(n_addr), .m_wdata(n_wd), .m_rd(n_rd), .m_wr(n_wr), .m_rdata(n_rdata),
    .s_addr(n_saddr), .s_wdata(n_swd), .s_lane(n_lane), .s_rd(n_srd), .s_wr(n_swr),
    .s_rdata(n_srdata));

  bus_width_adapter #(.AW(8), .SLAVE_W(64)) u_dut_w (
    .m_addr(w_addr), .m_wdata(w_wd), .m_rd(w_rd), .m_wr(w_wr), .m_rdata(w_rdata),
    .s_addr(w_saddr), .s_wdata(w_swd), .s_lane(w_lane), .s_rd(w_srd), .s_wr(w_swr),
    .s_rdata(w_srdata));

  // slave storage models
  logic [15:0] mem_n [128];
  logic [63:0] mem_w [32];
  assign n_srdata = mem_n[n_saddr];
  assign w_srdata = mem_w[w_saddr];

  always_ff @(posedge clk) begin
    if (rst_n && n_swr && n_lane[0]) mem_n[n_saddr] <= n_swd;
    if (rst_n && w_swr) begin
      if (w_lane[0]) mem_w[w_saddr][31:0]  <= w_swd[31:0];
      if (w_lane[1]) mem_w[w_saddr][63:32] <= w_swd[63:32];
    end
  end

  // master-view byte images
  logic [7:0] rb_n [256];
  logic [7:0] rb_w [256];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic n_step(int a, logic [31:0] d, int op);
    int b;
    b = a & 254;
    @(negedge clk);
    n_addr = b[7:1]; n_wd = d; n_rd = (op == 1); n_wr = (op == 2);
    #2;
    chk("R2 R3 narrow read", {32'h0, n_rdata}, {48'h0, rb_n[b+1], rb_n[b]});
    chk("R7 narrow strobes", {62'h0, n_srd, n_swr}, {62'h0, op == 1, op == 2});
    chk("R8 narrow lane", {63'h0, n_lane}, 64'h1);
    if (op == 2) begin
      chk("R1 narrow wdata", {48'h0, n_swd}, {48'h0, (b & 2) != 0 ? d[31:16] : d[15:0]});
      chk("R3 narrow saddr", {57'h0, n_saddr}, 64'(b >> 1));
      if ((b & 2) != 0) begin rb_n[b] = d[23:16]; rb_n[b+1] = d[31:24]; end
      else begin rb_n[b] = d[7:0]; rb_n[b+1] = d[15:8]; end
    end
  endtask

  task automatic w_step(int a, logic [31:0] d, int op);
    int b;
    b = a & 252;
    @(negedge clk);
    w_addr = b[7:2]; w_wd = d; w_rd = (op == 1); w_wr = (op == 2);
    #2;
    chk("R4 R6 wide read", {32'h0, w_rdata}, {32'h0, rb_w[b+3], rb_w[b+2], rb_w[b+1], rb_w[b]});
    chk("R7 wide strobes", {62'h0, w_srd, w_swr}, {62'h0, op == 1, op == 2});
    if (op == 2) begin
      chk("R5 wide lane", {62'h0, w_lane}, (b & 4) != 0 ? 64'h2 : 64'h1);
      chk("R5 wide dup", w_swd, {d, d});
      chk("R6 wide saddr", {59'h0, w_saddr}, 64'(b >> 3));
      rb_w[b] = d[7:0]; rb_w[b+1] = d[15:8]; rb_w[b+2] = d[23:16]; rb_w[b+3] = d[31:24];
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem_n[i] = '0;
    for (int i = 0; i < 32; i++) mem_w[i] = '0;
    for (int i = 0; i < 256; i++) begin rb_n[i] = '0; rb_w[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset idle narrow", {62'h0, n_srd, n_swr}, 64'h0);
    chk("R2 reset rdata narrow", {32'h0, n_rdata}, 64'h0);
    chk("R4 reset rdata wide", {32'h0, w_rdata}, 64'h0);
    chk("R7 reset idle wide", {62'h0, w_srd, w_swr}, 64'h0);
    rst_n = 1'b1;

    // directed: R8 neighbour halves preserved
    n_step(2, 32'hBEEF_1234, 2);
    n_step(0, 32'h5555_CAFE, 2);
    n_step(0, 32'h0, 1);
    n_step(2, 32'h0, 1);
    n_step(2, 32'hA5A5_0000, 2);
    n_step(0, 32'h0, 1);
    n_step(2, 32'h0, 1);
    n_step(6, 32'h7777_8888, 2);
    n_step(4, 32'h0, 1);
    n_step(6, 32'h0, 1);

    w_step(0, 32'h1111_1111, 2);
    w_step(4, 32'h2222_2222, 2);
    w_step(0, 32'h0, 1);
    w_step(4, 32'h0, 1);
    w_step(4, 32'hDEAD_BEEF, 2);
    w_step(0, 32'h0, 1);
    w_step(4, 32'h0, 1);
    w_step(8, 32'h0, 1);

    for (int i = 0; i < 400; i++) n_step($urandom_range(0, 31), $urandom, $urandom_range(0, 2));
    for (int i = 0; i < 400; i++) w_step($urandom_range(0, 63), $urandom, $urandom_range(0, 2));
    for (int i = 0; i < 200; i++) n_step($urandom_range(0, 255), $urandom, $urandom_range(0, 2));
    for (int i = 0; i < 200; i++) w_step($urandom_range(0, 255), $urandom, $urandom_range(0, 2));

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule